// File: doc/BRIEF.md
# Grouped Interrupt Flag Multiplexer

This block gathers external interrupt requests into a 16-bit pending-flag register and masks them with a 16-bit mask register. It drives four level-sensitive interrupt lines toward a processor. Each line serves a fixed, non-contiguous set of source bits. Each request input is synchronized with two flops. The rising edge of the synchronized input latches the matching flag, so a request is held until software clears it.

Software reaches the block through a single-cycle register port made of an address, a write strobe, write data and read data. The mask register can be read and written. The flag register reads back the raw pending bits, whatever the mask holds. Writing the flag register clears each flag whose bit in the written word is zero. A typical handler masks the group it is serving, clears the flags it has taken, and then restores the mask.

Top module: `irq_group_mux`

## Requirements
- R1: After reset the mask register reads 0x7FFE, the flag register reads 0x0000 and all four interrupt outputs are low.
- R2: The mask register is at address 0x4, is fully readable and writable, and a 1 in bit n masks source n.
- R3: The flag register is at address 0xC and reads the raw pending bits whatever the mask holds.
- R4: A write to address 0xC clears every flag whose write-data bit is 0 and leaves the flags written as 1 unchanged.
- R5: A flag is set by a rising edge of its request after a two-flop synchronizer. A request held high does not set the flag again after it has been cleared.
- R6: Output 0 serves bits 3 and 5. Output 1 serves bits 4 and 6. Output 2 serves bits 10 to 12. Output 3 serves bits 1, 2, 7, 8, 9, 13 and 14. Each output is high while any of its bits is both pending and unmasked.
- R7: Flag bits 0 and 15 latch like the others but drive no output.
- R8: Masking a pending source removes it from its output and leaves its flag set. Unmasking it asserts the output again.
- R9: When a request edge and a flag write that clears that flag fall in the same cycle, the flag ends up set.
- R10: The outputs are registered and follow a flag or mask update one clock later.
- R11: Reads of any address other than 0x4 and 0xC return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 16 | Asynchronous interrupt request inputs, one per flag bit |
| addr_i | input | 4 | Register address |
| we_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 4 | Level-sensitive grouped interrupt outputs |

## Verification
On every cycle the assertions check three things: that each output equals the group reduction of the previous cycle's pending and unmasked bits, that a flag write clears only the zero-written bits, and that a detected edge always leaves its flag set. They also check that mask writes land and that unmapped reads return zero. Other behaviour shows only in the bench's scenarios: the exact synchronizer latency, that a held request does not set its flag again, and the collision of a request edge with a clearing write in one cycle. The per-bit sweep and the mask sweep bring out the group mapping, including the two unrouted bits.

// File: rtl/irq_mux_pkg.sv
package irq_mux_pkg;
  localparam int unsigned FLAG_W  = 16;
  localparam int unsigned NUM_OUT = 4;
  localparam int unsigned ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 4'hC;

  localparam logic [FLAG_W-1:0] MASK_RST = 16'h7FFE;

  // group select per output line, index 0 in the low slot
  localparam logic [NUM_OUT-1:0][FLAG_W-1:0] GROUP_SEL = {
    16'h6386, 16'h1C00, 16'h0050, 16'h0028
  };
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sync_q1, sync_q2, last_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q1[b] <= 1'b0;
        sync_q2[b] <= 1'b0;
        last_q[b]  <= 1'b0;
      end else begin
        sync_q1[b] <= req_i[b];
        sync_q2[b] <= sync_q1[b];
        last_q[b]  <= sync_q2[b];
      end
    end
    assign rise_o[b] = sync_q2[b] & ~last_q[b];
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned        W         = 16,
  parameter int unsigned        AW        = 4,
  parameter logic [AW-1:0]      MASK_ADDR = 4'h4,
  parameter logic [AW-1:0]      FLAG_ADDR = 4'hC,
  parameter logic [W-1:0]       MASK_INIT = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  rise_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  flag_o,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mask_q, flag_q, flag_d, clr_vec;
  logic         mask_wr, flag_wr;

  assign mask_wr = we_i && (addr_i == MASK_ADDR);
  assign flag_wr = we_i && (addr_i == FLAG_ADDR);

  // zero-written bits clear; a fresh edge overrides the clear
  assign clr_vec = flag_wr ? ~wdata_i : '0;
  assign flag_d  = (flag_q & ~clr_vec) | rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_INIT;
      flag_q <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata_i;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      MASK_ADDR: rdata_o = mask_q;
      FLAG_ADDR: rdata_o = flag_q;
      default:   rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/irq_group_comb.sv
module irq_group_comb #(
  parameter int unsigned                 W     = 16,
  parameter int unsigned                 N     = 4,
  parameter logic [N-1:0][W-1:0]         GROUP = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] mask_i,
  output logic [N-1:0] irq_o
);
  logic [W-1:0] live;
  logic [N-1:0] irq_d, irq_q;

  assign live = flag_i & ~mask_i;

  for (genvar g = 0; g < N; g++) begin : g_out
    assign irq_d[g] = |(live & GROUP[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_group_mux.sv
module irq_group_mux
  import irq_mux_pkg::*;
#(
  parameter int unsigned                        W       = FLAG_W,
  parameter int unsigned                        N       = NUM_OUT,
  parameter int unsigned                        AW      = ADDR_W,
  parameter logic [N-1:0][W-1:0]                GROUP   = GROUP_SEL,
  parameter logic [W-1:0]                       MASK_IV = MASK_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  irq_req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [N-1:0]  irq_o
);
  logic [W-1:0] edge_rise, mask_reg, flag_reg;

  irq_req_sync #(.W(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req_i),
    .rise_o (edge_rise)
  );

  irq_flag_bank #(
    .W(W), .AW(AW), .MASK_ADDR(ADDR_MASK), .FLAG_ADDR(ADDR_FLAG), .MASK_INIT(MASK_IV)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (edge_rise),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .mask_o  (mask_reg),
    .flag_o  (flag_reg),
    .rdata_o (rdata_o)
  );

  irq_group_comb #(.W(W), .N(N), .GROUP(GROUP)) u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag_reg),
    .mask_i (mask_reg),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/irq_group_mux_chk.sv
module irq_group_mux_chk
  import irq_mux_pkg::*;
#(
  parameter int unsigned         W     = FLAG_W,
  parameter int unsigned         N     = NUM_OUT,
  parameter int unsigned         AW    = ADDR_W,
  parameter logic [N-1:0][W-1:0] GROUP = GROUP_SEL
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  rise_i,
  input logic [W-1:0]  flag_i,
  input logic [W-1:0]  mask_i,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  rdata_i,
  input logic [N-1:0]  irq_i
);
  logic [N-1:0] grp_act;
  logic         flag_wr, mask_wr, mapped;

  for (genvar g = 0; g < N; g++) begin : g_act
    assign grp_act[g] = (flag_i & ~mask_i & GROUP[g]) != '0;
  end

  assign flag_wr = we_i && (addr_i == ADDR_FLAG);
  assign mask_wr = we_i && (addr_i == ADDR_MASK);
  assign mapped  = (addr_i == ADDR_FLAG) || (addr_i == ADDR_MASK);

  p_out_follow_r6_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_i == $past(grp_act));

  p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr |=> flag_i == ($past(flag_i & wdata_i) | $past(rise_i)));

  p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> flag_i == ($past(flag_i) | $past(rise_i)));

  p_mask_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> mask_i == $past(wdata_i));

  for (genvar b = 0; b < W; b++) begin : g_bit
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i[b] |=> flag_i[b]);
  end

  always_comb begin
    if (rst_ni && !mapped) begin
      p_unmapped_zero_r11: assert (rdata_i == '0);
    end
  end
endmodule

bind irq_group_mux irq_group_mux_chk #(.W(W), .N(N), .AW(AW), .GROUP(GROUP)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rise_i  (edge_rise),
  .flag_i  (flag_reg),
  .mask_i  (mask_reg),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_i (rdata_o),
  .irq_i   (irq_o)
);

// File: tb/irq_group_mux_bench.sv
module irq_group_mux_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_req_i = '0;
  logic [3:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [3:0]  irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_group_mux u_irq_group_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [3:0] exp_irq(logic [15:0] f, logic [15:0] m);
    logic [3:0] r = '0;
    for (int b = 0; b < 16; b++) begin
      if (f[b] && !m[b]) begin
        case (b)
          3, 5:                    r[0] = 1'b1;
          4, 6:                    r[1] = 1'b1;
          10, 11, 12:              r[2] = 1'b1;
          1, 2, 7, 8, 9, 13, 14:   r[3] = 1'b1;
          default: ;
        endcase
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd_check(string req, logic [3:0] a, logic [15:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic pulse(logic [15:0] bits);
    @(negedge clk_i);
    irq_req_i = irq_req_i | bits;
    repeat (4) @(negedge clk_i);
    irq_req_i = irq_req_i & ~bits;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] m, prev_m;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd_check("R1 mask", 4'h4, 16'h7FFE);
    rd_check("R1 flag", 4'hC, 16'h0000);
    check("R1 irq", {12'h0, irq_o}, 16'h0);

    // R2 unmask everything
    wr(4'h4, 16'h0000);
    rd_check("R2 mask", 4'h4, 16'h0000);

    // R5/R6/R7 per-bit sweep
    for (int b = 0; b < 16; b++) begin
      pulse(16'h1 << b);
      rd_check("R5 flag", 4'hC, 16'h1 << b);
      check((b == 0 || b == 15) ? "R7 irq" : "R6 irq",
            {12'h0, irq_o}, {12'h0, exp_irq(16'h1 << b, 16'h0)});
      wr(4'hC, ~(16'h1 << b));
      @(negedge clk_i);
      rd_check("R4 clear", 4'hC, 16'h0000);
      check("R10 irq drop", {12'h0, irq_o}, 16'h0);
    end

    // all flags pending, mask sweep
    pulse(16'hFFFF);
    rd_check("R5 all", 4'hC, 16'hFFFF);
    prev_m = 16'h0000;
    for (int k = 0; k < 400; k++) begin
      m = 16'(k * 16'h3A5B) ^ 16'(k << 7);
      wr(4'h4, m);
      check("R10 old", {12'h0, irq_o}, {12'h0, exp_irq(16'hFFFF, prev_m)});
      @(negedge clk_i);
      check("R6 mask sweep", {12'h0, irq_o}, {12'h0, exp_irq(16'hFFFF, m)});
      rd_check("R2 readback", 4'h4, m);
      rd_check("R3 raw flag", 4'hC, 16'hFFFF);
      prev_m = m;
    end

    // R4 partial clear
    wr(4'hC, 16'hA5A5);
    rd_check("R4 partial", 4'hC, 16'hA5A5);

    // R8 mask then unmask a pending set
    wr(4'h4, 16'h0000);
    @(negedge clk_i);
    check("R8 live", {12'h0, irq_o}, {12'h0, exp_irq(16'hA5A5, 16'h0)});
    wr(4'h4, 16'hFFFF);
    @(negedge clk_i);
    check("R8 masked", {12'h0, irq_o}, 16'h0);
    rd_check("R8 flag kept", 4'hC, 16'hA5A5);
    wr(4'h4, 16'h0000);
    @(negedge clk_i);
    check("R8 unmasked", {12'h0, irq_o}, {12'h0, exp_irq(16'hA5A5, 16'h0)});
    wr(4'hC, 16'h0000);

    // R5 held level does not set the flag again
    @(negedge clk_i);
    irq_req_i[3] = 1'b1;
    repeat (4) @(negedge clk_i);
    rd_check("R5 level set", 4'hC, 16'h0008);
    wr(4'hC, 16'h0000);
    repeat (6) @(negedge clk_i);
    rd_check("R5 level no reset", 4'hC, 16'h0000);
    check("R5 level irq", {12'h0, irq_o}, 16'h0);
    irq_req_i[3] = 1'b0;
    repeat (4) @(negedge clk_i);

    // R9 edge and clear in the same cycle
    irq_req_i[10] = 1'b1;        // captured at edge k
    @(negedge clk_i);            // after k
    @(negedge clk_i);            // after k+1: edge detect high
    addr_i = 4'hC; wdata_i = 16'h0000; we_i = 1'b1;
    @(negedge clk_i);            // after k+2
    we_i = 1'b0;
    rd_check("R9 set wins", 4'hC, 16'h0400);
    irq_req_i[10] = 1'b0;
    repeat (4) @(negedge clk_i);
    wr(4'hC, 16'h0000);

    // R11 unmapped address
    wr(4'h4, 16'h1234);
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'hFFFF);
    rd_check("R11 read 8", 4'h8, 16'h0000);
    rd_check("R11 read 0", 4'h0, 16'h0000);
    rd_check("R11 mask kept", 4'h4, 16'h1234);
    rd_check("R11 flag kept", 4'hC, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule